// File: doc/BRIEF.md
# FIFO Reset Sequencer and Flag Offset Loader

This block brings a dual-clock FIFO out of reset. A single active-low reset request may change at any moment with respect to the write clock (`clk_a`) or the read clock (`clk_b`). Each clock domain brings the request in through its own synchronizer chain. While the request is low, the block holds the flag outputs of each domain at their reset values and asserts the pointer-clear strobe for that domain. Each domain also counts the clock edges that see the request low. Together these counts decide whether the reset was long enough.

When the request rises, the block latches the almost-full/almost-empty offset from a two-bit select input. Two further write-clock edges after the release reaches the write domain, the full flag lets go. The flag outputs use active-low meaning: a low `full_n` means "full", and a low `empty_n` means "empty". After release, every flag except `full_n` keeps its reset value. From that point the FIFO's own flag logic, which sits outside this block, takes over.

Top module: `fifo_rst_seq`

## Requirements
- R1: `reset_ok` reads 1 after a reset during which the request stayed low across at least 4 rising edges of `clk_a` and at least 4 rising edges of `clk_b`. The count of 4 includes the exact boundary of 4 and 4.
- R2: `reset_ok` reads 0 after a reset that saw fewer than 4 low edges (but at least one) in either domain. The status value then holds unchanged until the next reset.
- R3: No later than the 3rd edge of its own clock after the request falls, and for as long as the reset lasts, each domain shows its reset flag values. The write domain shows `full_n`=0, `afull_n`=1 and `mbx_ba_n`=1. The read domain shows `empty_n`=0, `aempty_n`=0 and `mbx_ab_n`=1.
- R4: `wr_ptr_clr` and `rd_ptr_clr` are high while the reset is in effect. Each goes low on the 3rd rising edge of its own clock after the request rises.
- R5: `full_n` stays low through the 3rd `clk_a` edge after the request rises and becomes 1 on the 4th edge. That is two synchronizer stages plus a release delay of two edges.
- R6: On the rising edge of the request, `ofs_val` loads 4×(sel+1). The select codes map as 2'b00→4, 2'b01→8, 2'b10→12 and 2'b11→16.
- R7: `ofs_sel` is ignored at every moment other than the request's rising edge. Values that are changed during the reset and then replaced, or that are changed after release, leave `ofs_val` unaffected.
- R8: After release, `empty_n`, `aempty_n`, `afull_n`, `mbx_ab_n` and `mbx_ba_n` keep their reset values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_req_n | input | 1 | Asynchronous active-low reset request |
| ofs_sel | input | 2 | Offset select, latched on request rise |
| full_n | output | 1 | Full flag, low = full (clk_a domain) |
| afull_n | output | 1 | Almost-full flag, low = almost full (clk_a) |
| mbx_ba_n | output | 1 | Mailbox flag toward write side, high = empty (clk_a) |
| wr_ptr_clr | output | 1 | Write pointer clear (clk_a) |
| empty_n | output | 1 | Empty flag, low = empty (clk_b domain) |
| aempty_n | output | 1 | Almost-empty flag, low = almost empty (clk_b) |
| mbx_ab_n | output | 1 | Mailbox flag toward read side, high = empty (clk_b) |
| rd_ptr_clr | output | 1 | Read pointer clear (clk_b) |
| ofs_val | output | 6 | Almost-full/almost-empty offset |
| reset_ok | output | 1 | 1 when the last reset met both edge counts |

## Verification
Two events can land together:
- the last counted low edge of a domain and the start of release, and
- the offset capture and the first release step of the write domain.

Both are provoked in the bench. The boundary vector gates the write clock so that exactly four write edges and exactly four read edges fall inside the reset. The request then rises on the slot right after the fourth read edge, so validity is settled by the final counted edge itself. In the same step the select is changed during the reset and again just after release. The bench judges the outcome through `reset_ok`, `ofs_val` and the edge on which `full_n` rises.

// File: rtl/fifo_rst_seq_pkg.sv
// Package: shared reset values for the flag outputs of the FIFO reset sequencer.
// Assumes flags are active-low in meaning (low = condition present).
package fifo_rst_seq_pkg;

    // Flags owned by the write-clock domain (full flag is produced separately).
    typedef struct packed {
        logic afull_n;
        logic mbx_ba_n;
    } wr_flags_t;

    // Flags owned by the read-clock domain.
    typedef struct packed {
        logic empty_n;
        logic aempty_n;
        logic mbx_ab_n;
    } rd_flags_t;

    localparam wr_flags_t WR_FLAGS_RST = '{afull_n: 1'b1, mbx_ba_n: 1'b1};
    localparam rd_flags_t RD_FLAGS_RST = '{empty_n: 1'b0, aempty_n: 1'b0, mbx_ab_n: 1'b1};

endpackage

// File: rtl/fifo_rst_sync.sv
// Module: multi-stage synchronizer for an asynchronous active-low level.
// Assumes STAGES >= 2; carries no reset because it transports the reset itself.
module fifo_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the chain of flops.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], async_n};
    end

    assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/fifo_rst_domain.sv
// Module: per-clock-domain reset front end. Synchronizes the request, counts
// edges that see it low (saturating), keeps a pass/fail bit and drives the
// pointer-clear strobe. Assumes MIN_EDGES >= 1 and at least one clock edge
// per reset for the pass/fail bit to refresh.
module fifo_rst_domain #(
    parameter int unsigned STAGES    = 2,
    parameter int unsigned MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst_req_n,
    output logic rst_s_n,
    output logic edges_ok,
    output logic ptr_clr
);

    localparam int unsigned CNT_W = $clog2(MIN_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_EDGES - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_EDGES);

    logic [CNT_W-1:0] low_cnt;

    fifo_rst_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .async_n (rst_req_n),
        .sync_n  (rst_s_n)
    );

    // Count low edges during reset; judge validity on each counted edge.
    always_ff @(posedge clk) begin
        if (!rst_s_n) begin
            if (low_cnt != CNT_SAT) begin
                low_cnt <= low_cnt + 1'b1;
            end
            edges_ok <= (low_cnt >= CNT_LAST);
        end else begin
            low_cnt <= '0;
        end
    end

    // Hold the pointer clear for as long as the synchronized reset is low.
    always_ff @(posedge clk) begin
        ptr_clr <= !rst_s_n;
    end

endmodule

// File: rtl/fifo_rst_release.sv
// Module: delays the release of the full flag by DELAY edges after the
// synchronized reset goes high. Assumes DELAY >= 1.
module fifo_rst_release #(
    parameter int unsigned DELAY = 2
) (
    input  logic clk,
    input  logic rst_s_n,
    output logic released
);

    localparam int unsigned DLY_W = $clog2(DELAY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY - 1);

    logic [DLY_W-1:0] dly_cnt;

    // Count edges after release and raise the output on the last one.
    always_ff @(posedge clk) begin
        if (!rst_s_n) begin
            dly_cnt  <= '0;
            released <= 1'b0;
        end else if (!released) begin
            if (dly_cnt == DLY_LAST) begin
                released <= 1'b1;
            end else begin
                dly_cnt <= dly_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fifo_rst_offset.sv
// Module: captures the flag offset on the rising edge of the reset request.
// Assumes OFS_W is wide enough for OFS_STEP * 2**SEL_W.
module fifo_rst_offset #(
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned OFS_W    = 6,
    parameter int unsigned OFS_STEP = 4
) (
    input  logic             rst_req_n,
    input  logic [SEL_W-1:0] ofs_sel,
    output logic [OFS_W-1:0] ofs_val
);

    // Latch step*(code+1) when the request is released.
    always_ff @(posedge rst_req_n) begin
        ofs_val <= OFS_W'((int'(ofs_sel) + 1) * int'(OFS_STEP));
    end

endmodule

// File: rtl/fifo_rst_seq.sv
// Module: top of the FIFO reset sequencer. Runs one front end per clock
// domain, holds the flag reset values, delays the full release and latches
// the flag offset. Assumes flags are handed to external logic after release.
module fifo_rst_seq
    import fifo_rst_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_EDGES   = 4,
    parameter int unsigned FULL_DELAY  = 2,
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned OFS_W       = 6,
    parameter int unsigned OFS_STEP    = 4
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_req_n,
    input  logic [SEL_W-1:0] ofs_sel,
    output logic             full_n,
    output logic             afull_n,
    output logic             mbx_ba_n,
    output logic             wr_ptr_clr,
    output logic             empty_n,
    output logic             aempty_n,
    output logic             mbx_ab_n,
    output logic             rd_ptr_clr,
    output logic [OFS_W-1:0] ofs_val,
    output logic             reset_ok
);

    logic      rst_a_n, rst_b_n;
    logic      ok_a, ok_b;
    wr_flags_t wr_flags;
    rd_flags_t rd_flags;

    fifo_rst_domain #(.STAGES(SYNC_STAGES), .MIN_EDGES(MIN_EDGES)) u_dom_a (
        .clk       (clk_a),
        .rst_req_n (rst_req_n),
        .rst_s_n   (rst_a_n),
        .edges_ok  (ok_a),
        .ptr_clr   (wr_ptr_clr)
    );

    fifo_rst_domain #(.STAGES(SYNC_STAGES), .MIN_EDGES(MIN_EDGES)) u_dom_b (
        .clk       (clk_b),
        .rst_req_n (rst_req_n),
        .rst_s_n   (rst_b_n),
        .edges_ok  (ok_b),
        .ptr_clr   (rd_ptr_clr)
    );

    fifo_rst_release #(.DELAY(FULL_DELAY)) u_full_rel (
        .clk      (clk_a),
        .rst_s_n  (rst_a_n),
        .released (full_n)
    );

    fifo_rst_offset #(.SEL_W(SEL_W), .OFS_W(OFS_W), .OFS_STEP(OFS_STEP)) u_ofs (
        .rst_req_n (rst_req_n),
        .ofs_sel   (ofs_sel),
        .ofs_val   (ofs_val)
    );

    // Force write-side flags to their reset values during reset; hold after.
    always_ff @(posedge clk_a) begin
        if (!rst_a_n) begin
            wr_flags <= WR_FLAGS_RST;
        end
    end

    // Force read-side flags to their reset values during reset; hold after.
    always_ff @(posedge clk_b) begin
        if (!rst_b_n) begin
            rd_flags <= RD_FLAGS_RST;
        end
    end

    assign afull_n  = wr_flags.afull_n;
    assign mbx_ba_n = wr_flags.mbx_ba_n;
    assign empty_n  = rd_flags.empty_n;
    assign aempty_n = rd_flags.aempty_n;
    assign mbx_ab_n = rd_flags.mbx_ab_n;
    assign reset_ok = ok_a & ok_b;

endmodule

// File: rtl/fifo_rst_seq_chk.sv
// Module: assertion checker for fifo_rst_seq, attached by bind below.
// Assumes properties are armed only after a domain has seen reset low.
module fifo_rst_seq_chk #(
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned OFS_W    = 6,
    parameter int unsigned OFS_STEP = 4
) (
    input logic             clk_a,
    input logic             clk_b,
    input logic             rst_a_n,
    input logic             rst_b_n,
    input logic             ok_a,
    input logic             ok_b,
    input logic             full_n,
    input logic             afull_n,
    input logic             mbx_ba_n,
    input logic             wr_ptr_clr,
    input logic             empty_n,
    input logic             aempty_n,
    input logic             mbx_ab_n,
    input logic             rd_ptr_clr,
    input logic [OFS_W-1:0] ofs_val
);

    logic armed_a = 1'b0;
    logic armed_b = 1'b0;

    // Arm write-side checks once a synchronized reset has been observed.
    always_ff @(posedge clk_a) begin
        if (rst_a_n === 1'b0) armed_a <= 1'b1;
    end

    // Arm read-side checks once a synchronized reset has been observed.
    always_ff @(posedge clk_b) begin
        if (rst_b_n === 1'b0) armed_b <= 1'b1;
    end

    assert_wr_flags_R3: assert property (@(posedge clk_a) disable iff (!armed_a)
        !rst_a_n |=> (!full_n && afull_n && mbx_ba_n));

    assert_rd_flags_R3: assert property (@(posedge clk_b) disable iff (!armed_b)
        !rst_b_n |=> (!empty_n && !aempty_n && mbx_ab_n));

    assert_wr_clr_on_R4: assert property (@(posedge clk_a) disable iff (!armed_a)
        !rst_a_n |=> wr_ptr_clr);

    assert_wr_clr_off_R4: assert property (@(posedge clk_a) disable iff (!armed_a)
        rst_a_n |=> !wr_ptr_clr);

    assert_rd_clr_on_R4: assert property (@(posedge clk_b) disable iff (!armed_b)
        !rst_b_n |=> rd_ptr_clr);

    assert_full_late_R5: assert property (@(posedge clk_a) disable iff (!armed_a)
        $rose(full_n) |-> (rst_a_n && $past(rst_a_n) && $past(rst_a_n, 2)));

    assert_ofs_legal_R6: assert property (@(posedge clk_a) disable iff (!armed_a || !rst_a_n)
        ((int'(ofs_val) % int'(OFS_STEP)) == 0) && (ofs_val != '0)
        && (int'(ofs_val) <= int'(OFS_STEP) * (1 << SEL_W)));

    assert_ok_a_hold_R2: assert property (@(posedge clk_a) disable iff (!armed_a)
        (rst_a_n && $past(rst_a_n)) |-> $stable(ok_a));

    assert_ok_b_hold_R2: assert property (@(posedge clk_b) disable iff (!armed_b)
        (rst_b_n && $past(rst_b_n)) |-> $stable(ok_b));

    assert_rd_hold_R8: assert property (@(posedge clk_b) disable iff (!armed_b)
        rst_b_n |=> (!empty_n && !aempty_n && mbx_ab_n));

    assert_wr_hold_R8: assert property (@(posedge clk_a) disable iff (!armed_a)
        rst_a_n |=> (afull_n && mbx_ba_n));

endmodule

bind fifo_rst_seq fifo_rst_seq_chk #(.SEL_W(SEL_W), .OFS_W(OFS_W), .OFS_STEP(OFS_STEP)) u_chk (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .rst_a_n    (rst_a_n),
    .rst_b_n    (rst_b_n),
    .ok_a       (ok_a),
    .ok_b       (ok_b),
    .full_n     (full_n),
    .afull_n    (afull_n),
    .mbx_ba_n   (mbx_ba_n),
    .wr_ptr_clr (wr_ptr_clr),
    .empty_n    (empty_n),
    .aempty_n   (aempty_n),
    .mbx_ab_n   (mbx_ab_n),
    .rd_ptr_clr (rd_ptr_clr),
    .ofs_val    (ofs_val)
);

// File: tb/tb_fifo_rst_seq.sv
// Bench for fifo_rst_seq. clk_a: 125 MHz (8 ns), posedges at 4+8k ns.
// clk_b: 16 ns, posedges at 8+16k ns. Stimulus moves only on multiples of
// 16 ns, which lie away from every edge of both clocks.
module tb_fifo_rst_seq;

    logic       clk_a_raw = 1'b0;
    logic       clk_b     = 1'b0;
    logic       a_run     = 1'b1;
    logic       clk_a;
    logic       rst_req_n = 1'b0;
    logic [1:0] ofs_sel   = 2'b00;
    logic       full_n, afull_n, mbx_ba_n, wr_ptr_clr;
    logic       empty_n, aempty_n, mbx_ab_n, rd_ptr_clr;
    logic [5:0] ofs_val;
    logic       reset_ok;

    int total = 0;
    int bad   = 0;

    always #4 clk_a_raw = ~clk_a_raw;
    always #8 clk_b     = ~clk_b;
    assign clk_a = clk_a_raw & a_run;

    fifo_rst_seq dut (
        .clk_a      (clk_a),
        .clk_b      (clk_b),
        .rst_req_n  (rst_req_n),
        .ofs_sel    (ofs_sel),
        .full_n     (full_n),
        .afull_n    (afull_n),
        .mbx_ba_n   (mbx_ba_n),
        .wr_ptr_clr (wr_ptr_clr),
        .empty_n    (empty_n),
        .aempty_n   (aempty_n),
        .mbx_ab_n   (mbx_ab_n),
        .rd_ptr_clr (rd_ptr_clr),
        .ofs_val    (ofs_val),
        .reset_ok   (reset_ok)
    );

    // sel, low time (16 ns units), write-clock run time (units), expected status, offset
    typedef struct packed {
        logic [1:0] sel;
        int         low_u;
        int         a_u;
        logic       ok;
        int         ofs;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd0, 4, 4, 1'b1,  4},
        '{2'd1, 3, 3, 1'b0,  8},
        '{2'd2, 4, 2, 1'b1, 12},
        '{2'd3, 4, 1, 1'b0, 16},
        '{2'd1, 6, 6, 1'b1,  8},
        '{2'd2, 2, 2, 1'b0, 12}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one reset from an aligned time; write clock runs a_u units of it.
    task automatic pulse_reset(input logic [1:0] sel, input int low_u, input int a_u);
        ofs_sel   = sel;
        rst_req_n = 1'b0;
        if (a_u < low_u) begin
            #(16 * a_u);
            a_run = 1'b0;
            #(16 * (low_u - a_u));
        end else begin
            #(16 * low_u);
        end
        rst_req_n = 1'b1;
        a_run     = 1'b1;
    endtask

    initial begin
        // Reset starts at t=0; write flags settle by the 3rd clk_a edge (20 ns).
        #22;
        check("R3 full_n in reset", int'(full_n), 0);
        check("R3 afull_n in reset", int'(afull_n), 1);
        check("R3 mbx_ba_n in reset", int'(mbx_ba_n), 1);
        check("R4 wr_ptr_clr in reset", int'(wr_ptr_clr), 1);
        #20; // 42 ns: 3rd clk_b edge at 40 ns
        check("R3 empty_n in reset", int'(empty_n), 0);
        check("R3 aempty_n in reset", int'(aempty_n), 0);
        check("R3 mbx_ab_n in reset", int'(mbx_ab_n), 1);
        check("R4 rd_ptr_clr in reset", int'(rd_ptr_clr), 1);
        #6;  // 48 ns: select changes mid-reset, only the final value counts (R7)
        ofs_sel = 2'b11;
        #16; // 64 ns: release; clk_a edges follow at +4,+12,+20,+28
        rst_req_n = 1'b1;
        #18 check("R4 wr_ptr_clr before 3rd edge", int'(wr_ptr_clr), 1);
        #4  check("R4 wr_ptr_clr after 3rd edge", int'(wr_ptr_clr), 0);
        #4  check("R5 full_n after 3rd edge", int'(full_n), 0);
        #4  check("R5 full_n after 4th edge", int'(full_n), 1);
        #6  check("R4 rd_ptr_clr before 3rd edge", int'(rd_ptr_clr), 1);
        #6  check("R4 rd_ptr_clr after 3rd edge", int'(rd_ptr_clr), 0);
        #54;
        check("R1 reset_ok after long reset", int'(reset_ok), 1);
        check("R6 R7 offset for code 11", int'(ofs_val), 16);
        check("R8 empty_n held", int'(empty_n), 0);
        check("R8 aempty_n held", int'(aempty_n), 0);
        check("R8 afull_n held", int'(afull_n), 1);
        check("R8 mbx_ab_n held", int'(mbx_ab_n), 1);
        check("R8 mbx_ba_n held", int'(mbx_ba_n), 1);

        // Vector walk: offsets per code and edge-count validity (R1 R2 R6).
        foreach (VEC[i]) begin
            pulse_reset(VEC[i].sel, VEC[i].low_u, VEC[i].a_u);
            #96;
            check(VEC[i].ok ? "R1 reset_ok vector" : "R2 reset_ok vector",
                  int'(reset_ok), int'(VEC[i].ok));
            check("R6 offset vector", int'(ofs_val), VEC[i].ofs);
            check("R5 full_n released vector", int'(full_n), 1);
        end

        // Select change after release is ignored (R7).
        ofs_sel = 2'b00;
        #32;
        check("R7 offset unchanged after release", int'(ofs_val), 12);
        check("R2 status held after release", int'(reset_ok), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule